// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the protocol engine of a 256-byte serial EEPROM that answers on an I2C bus as a slave. It receives SCL and SDA already synchronised and oversampled by the local clock, and it answers through a single open-drain pull-down enable. It finds START and STOP conditions and decodes the control byte. It loads a word-address pointer and sequences byte writes, page writes, current-address reads, random reads and sequential reads.

Incoming write data goes to a separate page-buffer block. The engine announces a new page session, hands over each byte with its target address, and issues a one-cycle commit when the master ends a write with STOP. The page buffer reports through a busy input while its self-timed programming cycle runs. During that time the engine acknowledges nothing, so a master can poll for completion by repeatedly addressing it. Array contents are read through a synchronous port with one cycle of latency.

Top module: `ee_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. Bytes are only taken after a START, and a STOP returns the engine to idle with SDA released.
- R2: The first byte after START is a control byte, sent MSB first. Bits 7..4 must equal 4'b1010 for an acknowledge, bits 3..1 are ignored, and bit 0 selects read (1) or write (0). A control byte with any other top nibble gets no acknowledge, and the engine ignores the bus until the next START.
- R3: In a write, the byte after the control byte is the word address and loads the pointer. Every byte accepted in a write is acknowledged by holding SDA low through the ninth SCL high phase.
- R4: Each write data byte goes to the page buffer at the current pointer. After it, only pointer bits 2..0 increment (wrapping inside the 8-byte page) and bits 7..3 stay, so a page write of more than 8 bytes overwrites the earliest bytes of that page.
- R5: A STOP after at least one complete write data byte gives exactly one commit pulse. A STOP after only a control byte, or only a control byte and a word address, gives none.
- R6: While busy is high, no byte is acknowledged, including a matching control byte, and no data reaches the page buffer.
- R7: A read with no preceding address byte returns the byte at the pointer, which is one past the last byte accessed.
- R8: A write control byte and word address, then a repeated START and a read control byte, return the byte at that word address.
- R9: During reads the pointer increments over the whole array after each byte and wraps from 255 to 0. A master acknowledge yields the next byte, and a master no-acknowledge makes the engine release SDA.
- R10: The pull-down enable changes only while SCL is low, and never in the first sample after SCL falls.
- R11: A START in the middle of a byte abandons that byte and begins a new control byte. A STOP in the middle of a write data byte discards that partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| pg_open_o | output | 1 | Pulse: new page session, drop held bytes |
| pg_load_o | output | 1 | Pulse: write byte for the page buffer |
| pg_addr_o | output | ADDR_W | Array address of the byte being loaded |
| pg_data_o | output | 8 | Write byte being loaded |
| commit_o | output | 1 | Pulse: start the self-timed write cycle |
| busy_i | input | 1 | Self-timed write cycle running |
| rd_addr_o | output | ADDR_W | Read port address (the pointer) |
| rd_data_i | input | 8 | Read port data, one cycle after the address |

## Verification
A wrong pointer shows up at the first read byte after the fault as a value from the wrong location. Within one page, a corrupted page-offset wrap shows up as bytes missing or misplaced on readback. A bad byte counter or state slip shows up within nine SCL periods as a missing or misplaced acknowledge or a shifted data byte. Faulty busy gating shows up on the first poll after a commit as an acknowledge that should not be there. Losing the STOP qualification shows up as an extra or missing commit pulse at the end of the transaction.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;

    localparam int DATA_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_t;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_WADDR,
        PH_WDATA
    } rx_phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_match(input logic [DATA_W-1:0] b);
        return b[DATA_W-1:DATA_W-4] == DEV_CODE;
    endfunction

    function automatic logic ctrl_is_read(input logic [DATA_W-1:0] b);
        return b[0];
    endfunction

endpackage

// File: rtl/ee_bus_events.sv
module ee_bus_events
    import ee_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.sda   = sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);

    logic [PAGE_W-1:0] nxt_off;
    assign nxt_off = ptr[PAGE_W-1:0] + ONE_P;

    always_ff @(posedge clk) begin
        if (rst)            ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_full) ptr <= ptr + ONE_A;
        else if (step_page) ptr <= {ptr[ADDR_W-1:PAGE_W], nxt_off};
    end

    // R4
    page_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (step_page && !load && !step_full) |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

    // R9
    full_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_full && !load) |=> ptr == $past(ptr) + ONE_A);

endmodule

// File: rtl/ee_sda_hold.sv
module ee_sda_hold #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pull
);
    logic [HOLD_CYC-1:0] pipe;

    generate
        if (HOLD_CYC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= req;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[HOLD_CYC-2:0], req};
            end
        end
    endgenerate

    assign pull = pipe[HOLD_CYC-1];

endmodule

// File: rtl/ee_link_fsm.sv
module ee_link_fsm
    import ee_slave_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              pull_req,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              ptr_step_page,
    output logic              ptr_step_full,
    output logic              pg_open,
    output logic              pg_load,
    output logic [DATA_W-1:0] pg_data,
    output logic              commit
);
    link_state_t       state;
    rx_phase_t         phase;
    logic [3:0]        cnt;
    logic [DATA_W-1:0] sr;
    logic [DATA_W-1:0] txsr;
    logic              have_data;
    logic              mack;

    assign ptr_load_val = sr[ADDR_W-1:0];
    assign pg_data      = sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            phase         <= PH_CTRL;
            cnt           <= '0;
            sr            <= '0;
            txsr          <= '0;
            have_data     <= 1'b0;
            mack          <= 1'b0;
            pull_req      <= 1'b0;
            ptr_load      <= 1'b0;
            ptr_step_page <= 1'b0;
            ptr_step_full <= 1'b0;
            pg_open       <= 1'b0;
            pg_load       <= 1'b0;
            commit        <= 1'b0;
        end else begin
            ptr_load      <= 1'b0;
            ptr_step_page <= 1'b0;
            ptr_step_full <= 1'b0;
            pg_open       <= 1'b0;
            pg_load       <= 1'b0;
            commit        <= 1'b0;
            if (ev.start) begin
                state     <= ST_RX;
                phase     <= PH_CTRL;
                cnt       <= '0;
                have_data <= 1'b0;
                pull_req  <= 1'b0;
            end else if (ev.stop) begin
                commit    <= have_data;
                have_data <= 1'b0;
                state     <= ST_IDLE;
                pull_req  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.rise) begin
                            sr  <= {sr[DATA_W-2:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            cnt   <= '0;
                            state <= ST_RX_ACK;
                            case (phase)
                                PH_CTRL: begin
                                    if (ctrl_match(sr) && !busy_i) pull_req <= 1'b1;
                                    else                           state    <= ST_IDLE;
                                end
                                PH_WADDR: begin
                                    pull_req <= 1'b1;
                                    ptr_load <= 1'b1;
                                    pg_open  <= 1'b1;
                                end
                                default: begin
                                    pull_req      <= 1'b1;
                                    pg_load       <= 1'b1;
                                    ptr_step_page <= 1'b1;
                                    have_data     <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.fall) begin
                            pull_req <= 1'b0;
                            if (phase == PH_CTRL && ctrl_is_read(sr)) begin
                                state    <= ST_TX;
                                txsr     <= rd_data_i;
                                pull_req <= ~rd_data_i[DATA_W-1];
                                cnt      <= '0;
                            end else begin
                                state <= ST_RX;
                                phase <= (phase == PH_CTRL) ? PH_WADDR : PH_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (cnt == 4'd7) begin
                                pull_req      <= 1'b0;
                                ptr_step_full <= 1'b1;
                                state         <= ST_TX_ACK;
                                cnt           <= '0;
                            end else begin
                                txsr     <= {txsr[DATA_W-2:0], 1'b0};
                                pull_req <= ~txsr[DATA_W-2];
                                cnt      <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (mack) begin
                                txsr     <= rd_data_i;
                                pull_req <= ~rd_data_i[DATA_W-1];
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !pull_req);

    // R2
    ctrl_ack_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX_ACK && phase == PH_CTRL) |-> (pull_req && sr[DATA_W-1:DATA_W-4] == DEV_CODE));

    // R3
    ack_ninth_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && state == ST_RX_ACK) |-> pull_req);

    // R5
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R4
    side_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pg_open, pg_load, commit, ptr_step_full}));

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
    import ee_slave_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PAGE_W   = 3,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              pg_open_o,
    output logic              pg_load_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic [DATA_W-1:0] pg_data_o,
    output logic              commit_o,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i
);
    bus_ev_t           ev;
    logic              pull_req;
    logic              ptr_load, ptr_step_page, ptr_step_full;
    logic [ADDR_W-1:0] ptr_load_val;
    logic [ADDR_W-1:0] ptr;

    ee_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    ee_link_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .busy_i        (busy_i),
        .rd_data_i     (rd_data_i),
        .pull_req      (pull_req),
        .ptr_load      (ptr_load),
        .ptr_load_val  (ptr_load_val),
        .ptr_step_page (ptr_step_page),
        .ptr_step_full (ptr_step_full),
        .pg_open       (pg_open_o),
        .pg_load       (pg_load_o),
        .pg_data       (pg_data_o),
        .commit        (commit_o)
    );

    ee_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_val  (ptr_load_val),
        .step_page (ptr_step_page),
        .step_full (ptr_step_full),
        .ptr       (ptr)
    );

    ee_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .req  (pull_req),
        .pull (sda_pull_o)
    );

    assign pg_addr_o = ptr;
    assign rd_addr_o = ptr;

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);

endmodule

// File: tb/tb_ee_i2c_slave.sv
module tb_ee_i2c_slave;
    localparam int HALF     = 8;
    localparam int BUSY_CYC = 800;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m, sda_m;
    logic       line;
    logic       sda_pull, pg_open, pg_load, commit, busy;
    logic [7:0] pg_addr, pg_data, rd_addr, rd_data;

    always #5 clk = ~clk;

    assign line = sda_m & ~sda_pull;

    ee_i2c_slave dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (line),
        .sda_pull_o (sda_pull),
        .pg_open_o  (pg_open),
        .pg_load_o  (pg_load),
        .pg_addr_o  (pg_addr),
        .pg_data_o  (pg_data),
        .commit_o   (commit),
        .busy_i     (busy),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data)
    );

    int n_chk = 0, n_fail = 0, n_commit = 0, n_load = 0, n_viol = 0;

    function automatic logic [7:0] init_val(input logic [7:0] a);
        return (a * 8'd29) ^ 8'h5C;
    endfunction

    function automatic logic [7:0] page_next(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    // neighbour models: array, page buffer and write timer
    logic [7:0] mem [256];
    logic [7:0] pend_a [8];
    logic [7:0] pend_d [8];
    logic [7:0] pend_v;
    int         btimer;

    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
            busy   <= 1'b0;
            btimer <= 0;
            pend_v <= '0;
        end else begin
            if (pg_open) pend_v <= '0;
            if (pg_load) begin
                pend_a[pg_addr[2:0]] <= pg_addr;
                pend_d[pg_addr[2:0]] <= pg_data;
                pend_v[pg_addr[2:0]] <= 1'b1;
                n_load = n_load + 1;
            end
            if (commit) begin
                busy     <= 1'b1;
                btimer   <= BUSY_CYC;
                n_commit = n_commit + 1;
            end else if (busy) begin
                if (btimer == 1) begin
                    busy <= 1'b0;
                    for (int i = 0; i < 8; i++)
                        if (pend_v[i]) mem[pend_a[i]] <= pend_d[i];
                    pend_v <= '0;
                end
                btimer <= btimer - 1;
            end
        end
    end

    // R10 monitor: pull-down may change only with SCL low now and one sample ago
    logic prev_pull, prev_scl;
    always @(posedge clk) begin
        if (!rst && (sda_pull != prev_pull) && (scl_m || prev_scl)) n_viol = n_viol + 1;
        prev_pull <= sda_pull;
        prev_scl  <= scl_m;
    end

    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        @(negedge clk); sda_m = b;
        repeat (HALF) @(negedge clk);
        scl_m = 1'b1;
        repeat (HALF/2) @(negedge clk);
        r = line;
        repeat (HALF/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        @(negedge clk); sda_m = 1'b1;
        repeat (HALF) @(negedge clk); scl_m = 1'b1;
        repeat (HALF) @(negedge clk); sda_m = 1'b0;
        repeat (HALF) @(negedge clk); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk); sda_m = 1'b0;
        repeat (HALF) @(negedge clk); scl_m = 1'b1;
        repeat (HALF) @(negedge clk); sda_m = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
        bit_xfer(1'b1, r);
        ack = ~r;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d, output logic rel);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, r);
            d = {d[6:0], r};
        end
        bit_xfer(~give_ack, r);
        rel = r;
    endtask

    task automatic poll_ready(output int polls);
        logic ack;
        polls = 0;
        do begin
            bus_start();
            put_byte(8'hA0 | 8'({$urandom % 8, 1'b0}), ack);
            bus_stop();
            polls++;
        end while (!ack && polls < 40);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        logic ack;
        bus_start();
        put_byte({4'b1010, 3'($urandom), 1'b0}, ack);
        chk(ack, {tag, " R2 ctrl ack"}, ack, 1);
        put_byte(a, ack);
        chk(ack, {tag, " R3 addr ack"}, ack, 1);
        put_byte(d, ack);
        chk(ack, {tag, " R3 data ack"}, ack, 1);
        bus_stop();
        exp_mem[a] = d;
        exp_ptr    = page_next(a);
    endtask

    task automatic random_read(input logic [7:0] a, input int n, input string tag);
        logic ack, rel;
        logic [7:0] d;
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(a, ack);
        bus_start();
        put_byte(8'hA1, ack);
        chk(ack, {tag, " R8 read ctrl ack"}, ack, 1);
        exp_ptr = a;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n-1, d, rel);
            chk(d == exp_mem[exp_ptr], {tag, " R8 R9 read data"}, d, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        chk(rel == 1'b1, {tag, " R9 release after nack"}, rel, 1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ack, rel;
        logic [7:0] d;
        int polls, c0, l0;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(8'(i));
        exp_ptr = 8'h00;
        scl_m = 1'b1; sda_m = 1'b1; rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // reset state
        chk(sda_pull == 1'b0, "R1 reset pull released", sda_pull, 0);
        chk(n_commit == 0, "R5 reset no commit", n_commit, 0);

        // R2: wrong device code
        bus_start();
        put_byte(8'h50, ack);
        chk(!ack, "R2 wrong code nack", ack, 0);
        put_byte(8'hA1, ack);
        chk(!ack, "R2 ignored until START", ack, 0);
        bus_stop();

        // R2 chip-select bits ignored, byte write
        byte_write(8'h20, 8'h5A, "bw");
        chk(n_commit == 1, "R5 commit after data", n_commit, 1);

        // R6: busy refuses everything
        c0 = n_commit; l0 = n_load;
        bus_start();
        put_byte(8'hA0, ack);
        chk(!ack, "R6 busy nack ctrl", ack, 0);
        put_byte(8'h40, ack);
        put_byte(8'h11, ack);
        chk(!ack, "R6 busy nack data", ack, 0);
        bus_stop();
        chk(n_commit == c0 && n_load == l0, "R6 busy no load or commit", n_load, l0);

        poll_ready(polls);
        chk(n_commit == c0, "R5 poll stop no commit", n_commit, c0);

        // R7 current address read
        bus_start();
        put_byte(8'hA1, ack);
        get_byte(1'b0, d, rel);
        bus_stop();
        chk(d == exp_mem[exp_ptr], "R7 current address read", d, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;

        random_read(8'h20, 1, "rr");

        // R5: address only, then STOP: no commit
        c0 = n_commit;
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'h90, ack);
        bus_stop();
        chk(n_commit == c0, "R5 address only no commit", n_commit, c0);
        exp_ptr = 8'h90;

        // R4 page write of 10 bytes from 0x3D, wraps in page 0x38
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'h3D, ack);
        exp_ptr = 8'h3D;
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            put_byte(v, ack);
            chk(ack, "R3 page data ack", ack, 1);
            exp_mem[exp_ptr] = v;
            exp_ptr = page_next(exp_ptr);
        end
        bus_stop();
        chk(n_commit == c0 + 1, "R5 page commit", n_commit, c0 + 1);
        poll_ready(polls);
        chk(polls > 1, "R6 poll saw busy", polls, 2);
        // pointer stayed in page: current read returns 0x3F
        bus_start();
        put_byte(8'hA1, ack);
        get_byte(1'b0, d, rel);
        bus_stop();
        chk(d == exp_mem[8'h3F], "R4 pointer wrapped in page", d, exp_mem[8'h3F]);
        random_read(8'h38, 8, "pg");
        chk(exp_mem[8'h40] == init_val(8'h40), "R4 next page untouched", exp_mem[8'h40], init_val(8'h40));
        random_read(8'h40, 1, "pg2");

        // R9 sequential read wraps 255 -> 0
        random_read(8'hFE, 4, "wrap");
        bus_start();
        put_byte(8'hA1, ack);
        get_byte(1'b0, d, rel);
        bus_stop();
        chk(d == exp_mem[8'h02], "R9 R7 pointer after wrap", d, exp_mem[8'h02]);
        exp_ptr = 8'h03;

        // R11 START in mid-byte restarts control decode
        bus_start();
        bit_xfer(1'b1, rel); bit_xfer(1'b0, rel); bit_xfer(1'b1, rel); bit_xfer(1'b0, rel);
        bus_start();
        put_byte(8'hA1, ack);
        chk(ack, "R11 ack after mid-byte START", ack, 1);
        get_byte(1'b0, d, rel);
        bus_stop();
        chk(d == exp_mem[exp_ptr], "R11 data after restart", d, exp_mem[exp_ptr]);

        // R11 STOP in mid data byte discards it
        c0 = n_commit; l0 = n_load;
        bus_start();
        put_byte(8'hA0, ack);
        put_byte(8'h70, ack);
        bit_xfer(1'b0, rel); bit_xfer(1'b1, rel); bit_xfer(1'b1, rel);
        bus_stop();
        chk(n_commit == c0 && n_load == l0, "R11 partial byte dropped", n_commit, c0);
        random_read(8'h70, 1, "part");

        // random byte writes with readback
        for (int k = 0; k < 14; k++) begin
            logic [7:0] a, v;
            a = 8'($urandom);
            v = 8'($urandom);
            byte_write(a, v, "rnd");
            poll_ready(polls);
            random_read(a, 2, "rnd");
        end

        chk(n_viol == 0, "R10 pull changes only while SCL low", n_viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule